// File: doc/BRIEF.md
# Manchester Bit-Collision Receiver

This block turns a stream of Manchester-coded receive bits into decoded bits and bytes. Each bit arrives as two amplitude measurements, one for the early half and one for the late half of the bit period, qualified by a valid strobe. When only one half carries modulation, the stronger half selects the bit value. When both halves carry modulation, two transmitters answered at once and the block reports a bit collision.

A collision is declared when the weaker of the two half amplitudes is above a programmable 4-bit level. The block raises a sticky collision flag, records the position of the first collision in the frame, and keeps receiving. An optional mode forces every bit after the first collision to zero, which eases a software collision-resolution loop. Bytes are assembled least significant bit first, with an optional odd or even parity bit after each byte. A frame-start pulse clears all per-frame state.

Top module: `mcoll_rx`

## Requirements
- R1: A bit is a collision when min(amp_early, amp_late) is strictly greater than coll_level, with coll_level zero-extended. A bit that is not a collision decodes as 1 when amp_early > amp_late, and as 0 otherwise, ties included.
- R2: A collision bit is delivered as 1 on bit_out (unless R4 forces it), and reception of the following bits continues normally.
- R3: A collision sets coll_err, which stays set until frame_start.
- R4: With zac_en = 1, every bit after the first collision of the frame, colliding or not, is delivered as 0. The first collision bit itself is still delivered as 1.
- R5: coll_pos holds the index of the first collision bit in the frame. Bits are counted from 0 at frame start, parity bits included, and the count saturates at 255. Later collisions do not change coll_pos.
- R6: Data bits fill byte_data from the least significant bit upward. byte_valid pulses for one cycle, with byte_data, one cycle after the 8th data bit when par_en = 0, or one cycle after the parity bit when par_en = 1.
- R7: With par_en = 1, a parity bit follows every 8 data bits. par_err is set when the count of ones over the 8 delivered data bits and the delivered parity bit is even while par_odd = 1, or odd while par_odd = 0. par_err stays set until frame_start.
- R8: A collision on a parity bit sets par_err.
- R9: frame_start clears coll_err, par_err, coll_pos, the zero-forcing state and the bit and byte counters. A bit strobed in the same cycle as frame_start is discarded.
- R10: Every accepted bit, parity bits included, appears on bit_out with a one-cycle bit_valid pulse one clock after its in_valid.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Clears per-frame state |
| in_valid | input | 1 | Strobe qualifying one bit's half amplitudes |
| amp_early | input | 4 | Amplitude measured in the first half-bit |
| amp_late | input | 4 | Amplitude measured in the second half-bit |
| coll_level | input | 4 | Collision threshold |
| zac_en | input | 1 | Force bits after the first collision to zero |
| par_en | input | 1 | A parity bit follows each byte |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| bit_valid | output | 1 | A decoded bit is on bit_out |
| bit_out | output | 1 | Decoded bit |
| byte_valid | output | 1 | byte_data holds a completed byte |
| byte_data | output | 8 | Assembled byte, first bit in bit 0 |
| coll_err | output | 1 | A collision occurred in this frame |
| par_err | output | 1 | A parity mismatch or parity-bit collision occurred |
| coll_pos | output | 8 | Bit index of the first collision |

## Verification
The assertions assume that zac_en, par_en and par_odd stay constant within a frame and that frame_start is a lone pulse between frames. Once a frame has started, the zero-forcing and parity checks rely on those modes not changing. The stimulus changes modes only next to a frame_start pulse, and it drives in_valid for one cycle at a time with idle cycles between bits. The one case that strobes a bit together with frame_start is the test of the R9 discard rule.

// File: rtl/mcoll_pkg.sv
package mcoll_pkg;
  localparam int BYTE_W = 8;

  // Parity mismatch over a data byte plus its parity bit.
  function automatic logic parity_bad(input logic [BYTE_W-1:0] d, input logic p,
                                      input logic odd);
    return ((^d) ^ p) != odd;
  endfunction
endpackage

// File: rtl/mcoll_bitdec.sv
module mcoll_bitdec #(
  parameter int AMP_W = 4,
  parameter int LVL_W = 4
) (
  input  logic [AMP_W-1:0] amp_early,
  input  logic [AMP_W-1:0] amp_late,
  input  logic [LVL_W-1:0] level,
  output logic             coll,
  output logic             raw
);
  localparam int CMP_W = (AMP_W > LVL_W) ? AMP_W : LVL_W;

  function automatic logic [AMP_W-1:0] weaker(input logic [AMP_W-1:0] a,
                                              input logic [AMP_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  logic [CMP_W-1:0] weak_ext, lvl_ext;
  assign weak_ext = CMP_W'(weaker(amp_early, amp_late));
  assign lvl_ext  = CMP_W'(level);
  assign coll     = weak_ext > lvl_ext;
  assign raw      = amp_early > amp_late;
endmodule

// File: rtl/mcoll_track.sv
module mcoll_track #(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             acc,
  input  logic             coll,
  output logic             coll_err,
  output logic [POS_W-1:0] coll_pos
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] pos_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_cnt  <= '0;
      coll_err <= 1'b0;
      coll_pos <= '0;
    end else if (frame_start) begin
      pos_cnt  <= '0;
      coll_err <= 1'b0;
      coll_pos <= '0;
    end else if (acc) begin
      if (pos_cnt != POS_MAX) pos_cnt <= pos_cnt + 1'b1;
      if (coll && !coll_err) begin
        coll_err <= 1'b1;
        coll_pos <= pos_cnt;
      end
    end
  end

  p_pos_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_cnt == POS_MAX && !frame_start) |=> pos_cnt == POS_MAX);
  p_pos_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_err && !frame_start) |=> $stable(coll_pos));
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_err && !frame_start) |=> coll_err);
  p_frame_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!coll_err && coll_pos == '0 && pos_cnt == '0));
endmodule

// File: rtl/mcoll_framer.sv
module mcoll_framer
  import mcoll_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              acc,
  input  logic              bit_in,
  input  logic              coll,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              bit_valid,
  output logic              bit_out,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              par_err
);
  localparam int IDX_W = $clog2(BYTE_W + 1);
  localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] PAR_SLOT  = IDX_W'(BYTE_W);

  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] sh;
  logic              par_slot;
  logic [BYTE_W-1:0] sh_next;

  assign par_slot = (idx == PAR_SLOT);
  assign sh_next  = {bit_in, sh[BYTE_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx        <= '0;
      sh         <= '0;
      bit_valid  <= 1'b0;
      bit_out    <= 1'b0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      par_err    <= 1'b0;
    end else begin
      bit_valid  <= 1'b0;
      byte_valid <= 1'b0;
      if (frame_start) begin
        idx     <= '0;
        sh      <= '0;
        par_err <= 1'b0;
      end else if (acc) begin
        bit_valid <= 1'b1;
        bit_out   <= bit_in;
        if (par_slot) begin
          byte_data  <= sh;
          byte_valid <= 1'b1;
          idx        <= '0;
          if (coll || parity_bad(sh, bit_in, par_odd)) par_err <= 1'b1;
        end else begin
          sh <= sh_next;
          if (idx == LAST_DATA) begin
            if (par_en) begin
              idx <= PAR_SLOT;
            end else begin
              byte_data  <= sh_next;
              byte_valid <= 1'b1;
              idx        <= '0;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end

  p_byte_with_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> bit_valid);
  p_parity_coll_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !frame_start && par_slot && coll) |=> par_err);
  p_bit_echo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !frame_start) |=> (bit_valid && bit_out == $past(bit_in)));
endmodule

// File: rtl/mcoll_rx.sv
module mcoll_rx
  import mcoll_pkg::*;
#(
  parameter int AMP_W = 4,
  parameter int LVL_W = 4,
  parameter int POS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              in_valid,
  input  logic [AMP_W-1:0]  amp_early,
  input  logic [AMP_W-1:0]  amp_late,
  input  logic [LVL_W-1:0]  coll_level,
  input  logic              zac_en,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              bit_valid,
  output logic              bit_out,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              coll_err,
  output logic              par_err,
  output logic [POS_W-1:0]  coll_pos
);
  logic acc, coll_now, raw_now, forced, eff_bit;

  assign acc     = in_valid && !frame_start;
  assign forced  = zac_en && coll_err;
  assign eff_bit = forced ? 1'b0 : (coll_now ? 1'b1 : raw_now);

  mcoll_bitdec #(.AMP_W(AMP_W), .LVL_W(LVL_W)) u_dec (
    .amp_early(amp_early), .amp_late(amp_late), .level(coll_level),
    .coll(coll_now), .raw(raw_now));

  mcoll_track #(.POS_W(POS_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .acc(acc),
    .coll(coll_now), .coll_err(coll_err), .coll_pos(coll_pos));

  mcoll_framer u_frm (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .acc(acc),
    .bit_in(eff_bit), .coll(coll_now), .par_en(par_en), .par_odd(par_odd),
    .bit_valid(bit_valid), .bit_out(bit_out), .byte_valid(byte_valid),
    .byte_data(byte_data), .par_err(par_err));

  p_coll_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && coll_now && !forced) |=> bit_out);
  p_coll_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && coll_now) |=> coll_err);
  p_zero_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && zac_en && coll_err) |=> !bit_out);
  p_discard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !bit_valid);
endmodule

// File: tb/sim_mcoll_rx.sv
module sim_mcoll_rx;
  localparam int CLK_NS = 10;
  // Vector: {amp_early[4], amp_late[4], level[4], exp_bit, exp_coll}
  localparam int NV = 10;
  localparam logic [13:0] VEC [NV] = '{
    {4'd12, 4'd1,  4'd4,  1'b1, 1'b0},
    {4'd1,  4'd12, 4'd4,  1'b0, 1'b0},
    {4'd5,  4'd5,  4'd4,  1'b1, 1'b1},
    {4'd4,  4'd9,  4'd4,  1'b0, 1'b0},
    {4'd9,  4'd4,  4'd4,  1'b1, 1'b0},
    {4'd6,  4'd6,  4'd6,  1'b0, 1'b0},
    {4'd7,  4'd6,  4'd5,  1'b1, 1'b1},
    {4'd15, 4'd15, 4'd14, 1'b1, 1'b1},
    {4'd0,  4'd0,  4'd0,  1'b0, 1'b0},
    {4'd15, 4'd15, 4'd15, 1'b0, 1'b0}
  };

  logic clk = 0, rst_n = 0, frame_start = 0, in_valid = 0;
  logic [3:0] amp_early = 0, amp_late = 0, coll_level = 4'd4;
  logic zac_en = 0, par_en = 0, par_odd = 0;
  logic bit_valid, bit_out, byte_valid, coll_err, par_err;
  logic [7:0] byte_data, coll_pos;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  mcoll_rx u0 (.clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
    .amp_early(amp_early), .amp_late(amp_late), .coll_level(coll_level), .zac_en(zac_en),
    .par_en(par_en), .par_odd(par_odd), .bit_valid(bit_valid), .bit_out(bit_out),
    .byte_valid(byte_valid), .byte_data(byte_data), .coll_err(coll_err),
    .par_err(par_err), .coll_pos(coll_pos));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start_frame();
    @(negedge clk) frame_start = 1; in_valid = 0;
    @(negedge clk) frame_start = 0;
  endtask

  task automatic send(input logic [3:0] a, input logic [3:0] b);
    @(negedge clk) in_valid = 1; amp_early = a; amp_late = b;
    @(negedge clk) in_valid = 0;
  endtask

  task automatic send_clean(input logic v);
    if (v) send(4'd12, 4'd1); else send(4'd1, 4'd12);
  endtask

  task automatic send_coll();
    send(4'd10, 4'd9);
  endtask

  task automatic send_byte(input logic [7:0] d);
    for (int i = 0; i < 8; i++) send_clean(d[i]);
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 3);
    // R11 reset state
    chk("R11 bit_valid", bit_valid, 0); chk("R11 byte_valid", byte_valid, 0);
    chk("R11 coll_err", coll_err, 0);   chk("R11 coll_pos", coll_pos, 0);
    chk("R11 par_err", par_err, 0);     chk("R11 byte_data", byte_data, 0);
    @(negedge clk) rst_n = 1;

    // R1 R2 R3 R10: per-bit decode table
    for (int k = 0; k < NV; k++) begin
      start_frame();
      coll_level = VEC[k][5:2];
      send(VEC[k][13:10], VEC[k][9:6]);
      chk("R10 bit_valid", bit_valid, 1);
      chk("R1 R2 bit_out", bit_out, VEC[k][1]);
      chk("R3 coll_err", coll_err, VEC[k][0]);
    end
    coll_level = 4'd4;

    // R10 pulse is one cycle
    @(negedge clk); chk("R10 bit_valid drops", bit_valid, 0);

    // R6 byte assembly without parity
    start_frame();
    send_byte(8'hA5);
    chk("R6 byte_valid", byte_valid, 1); chk("R6 byte_data", byte_data, 8'hA5);
    @(negedge clk); chk("R6 byte_valid one cycle", byte_valid, 0);

    // R7 odd parity ok, then bad
    start_frame(); par_en = 1; par_odd = 1;
    send_byte(8'h3C);
    chk("R6 no byte before parity", byte_valid, 0);
    send_clean(1);
    chk("R6 byte after parity", byte_valid, 1); chk("R6 data", byte_data, 8'h3C);
    chk("R7 odd ok", par_err, 0);
    send_byte(8'h3C); send_clean(0);
    chk("R7 odd bad", par_err, 1); chk("R7 byte still out", byte_data, 8'h3C);

    // R7 even parity ok, R9 clear of par_err
    start_frame(); par_odd = 0;
    chk("R9 par_err cleared", par_err, 0);
    send_byte(8'h07); send_clean(1);
    chk("R7 even ok", par_err, 0);
    send_byte(8'h07); send_clean(0);
    chk("R7 even bad", par_err, 1);

    // R8 collision on parity bit (odd parity, data 0 so parity value 1 is correct)
    start_frame(); par_odd = 1;
    send_byte(8'h00); send_coll();
    chk("R8 parity coll par_err", par_err, 1); chk("R2 parity bit", bit_out, 1);
    chk("R5 pos of parity bit", coll_pos, 8);
    par_en = 0; par_odd = 0;

    // R5 R2 first position held, reception continues
    start_frame();
    send_clean(0); send_clean(0); send_clean(0); send_coll();
    send_clean(0); send_coll(); send_clean(0); send_clean(0);
    chk("R5 first pos", coll_pos, 3); chk("R2 continues byte", byte_data, 8'h28);
    chk("R3 coll_err", coll_err, 1);

    // R4 zero after collision
    start_frame(); zac_en = 1;
    send_clean(1); send_coll();
    chk("R4 first coll bit is 1", bit_out, 1);
    send_clean(1);
    chk("R4 forced zero", bit_out, 0);
    send_clean(1); send_coll();
    chk("R4 forced on later coll", bit_out, 0);
    send_clean(1); send_clean(1); send_clean(1);
    chk("R4 byte", byte_data, 8'h03); chk("R5 pos", coll_pos, 1);
    zac_en = 0;

    // R5 near saturation
    start_frame();
    for (int i = 0; i < 254; i++) send_clean(0);
    send_coll();
    chk("R5 pos 254", coll_pos, 254);
    start_frame();
    for (int i = 0; i < 300; i++) send_clean(1);
    send_coll();
    chk("R5 saturate", coll_pos, 255);

    // R9 clears, and a bit coincident with frame_start is discarded
    @(negedge clk) frame_start = 1; in_valid = 1; amp_early = 4'd10; amp_late = 4'd9;
    @(negedge clk) frame_start = 0; in_valid = 0;
    chk("R9 discarded bit", bit_valid, 0); chk("R9 coll_err", coll_err, 0);
    chk("R9 coll_pos", coll_pos, 0);
    send_coll();
    chk("R9 counter restarted", coll_pos, 0); chk("R3 set again", coll_err, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule